// File: doc/BRIEF.md
# Receive Character Framer

The framer sits behind clock and data recovery on a serial receive path. Each clock cycle with the bit-rate enable high, it takes one recovered bit and shifts it into a window. It then groups the bits into parallel characters. The width select picks 10-bit or 12-bit characters. Every completed character is presented on a parallel output together with a one-cycle valid strobe.

With the framer enable high, the most recent character-width of bits is compared on every bit against the sync pattern for the selected width. If the pattern completes anywhere other than on the present boundary, the unfinished character is dropped and the boundary restarts right after the pattern. A one-cycle realign pulse marks the change. With the enable low, the boundary is frozen, so an aliased pattern in corrupted data cannot move it. Decoding of the characters is done downstream.

Top module: `char_framer`

## Requirements
- R1: After reset, `char_valid`, `realign` and `char_out` are all zero. The first `char_valid` pulse follows the enabled cycle that carries the N-th bit after reset (N = 10 or 12).
- R2: With `narrow_sel` high, characters are 10 bits wide. The earliest received bit of a character appears at `char_out[0]` and the latest at `char_out[9]`, and `char_out[11:10]` reads zero.
- R3: With `narrow_sel` low, characters are 12 bits wide. The earliest received bit appears at `char_out[0]` and the latest at `char_out[11]`.
- R4: With `frame_en` high, a sync pattern that completes off the current boundary gives one `realign` pulse. The pulse appears in the cycle after the enabled cycle carrying the pattern's last bit. The unfinished character is discarded.
- R5: After a realign, the next character output consists of the N bits that follow the sync pattern.
- R6: A sync pattern that falls exactly on the current boundary is output as an ordinary character, and no `realign` pulse is given.
- R7: With `frame_en` low, `realign` never pulses and characters keep the boundary established before, even when a sync pattern passes.
- R8: The sync pattern for 10-bit mode is 0x3E0 (five zeros, then five ones, in arrival order). For 12-bit mode it is 0xFC0 (six zeros, then six ones). A 10-bit pattern arriving in 12-bit mode does not realign.
- R9: No sync match is recognised until N bits have been received since reset.
- R10: Cycles with `bit_en` low change no state. `char_valid` and `realign` are each high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Bit-rate enable; one bit is taken per high cycle |
| bit_in | input | 1 | Recovered serial bit |
| narrow_sel | input | 1 | 1 selects 10-bit characters, 0 selects 12-bit |
| frame_en | input | 1 | Allows the boundary to move to a detected sync pattern |
| char_out | output | 12 | Assembled character, earliest bit in bit 0 |
| char_valid | output | 1 | One-cycle strobe for a new character |
| realign | output | 1 | One-cycle pulse when the boundary moves |

## Verification
For both widths, the sync pattern is swept across every bit offset from the reset boundary. This separates a true realignment from the zero-offset case, where the pattern must come out as a plain character. It also shows that the characters after a realign start right after the pattern. Streams with a sync pattern and the framer disabled, and a 10-bit pattern sent in 12-bit mode, separate a frozen boundary from a moved one. A stream that starts with five ones tells a guarded start-up from a false match against reset zeros. Runs with idle gaps between bits separate single-cycle pulses from stretched ones.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int NARROW_W_DEF = 10;
  localparam int WIDE_W_DEF   = 12;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } width_mode_e;
endpackage

// File: rtl/framer_shift.sv
module framer_shift #(
  parameter int NARROW_W = 10,
  parameter int WIDE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              bit_in_i,
  input  logic              narrow_i,
  output logic [WIDE_W-1:0] win_o,
  output logic              win_full_o
);
  localparam int FW  = $clog2(WIDE_W + 1);
  localparam int FWP = FW + 1;
  localparam logic [FWP-1:0] NEED_N = FWP'(NARROW_W);
  localparam logic [FWP-1:0] NEED_W = FWP'(WIDE_W);
  localparam logic [FW-1:0]  SAT    = FW'(WIDE_W);

  logic [WIDE_W-1:0] sr_q, sr_d, sr_next;
  logic [FW-1:0]     fill_q, fill_d;
  logic [FWP-1:0]    fill_inc;

  // newest bit enters at the top, so the oldest bit of a window is lowest
  always_comb begin
    sr_next = {bit_in_i, sr_q[WIDE_W-1:1]};
    sr_d    = bit_en_i ? sr_next : sr_q;
    fill_d  = fill_q;
    if (bit_en_i && (fill_q != SAT)) fill_d = fill_q + FW'(1);
    fill_inc = {1'b0, fill_q} + FWP'(1);
  end

  always_comb begin
    if (narrow_i == framer_pkg::MODE_NARROW) begin
      win_o      = {{(WIDE_W-NARROW_W){1'b0}}, sr_next[WIDE_W-1 -: NARROW_W]};
      win_full_o = (fill_inc >= NEED_N);
    end else begin
      win_o      = sr_next;
      win_full_o = (fill_inc >= NEED_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end

  p_fill_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= SAT);

  p_fill_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> $stable(sr_q));
endmodule

// File: rtl/framer_sync_det.sv
module framer_sync_det #(
  parameter int                  NARROW_W    = 10,
  parameter int                  WIDE_W      = 12,
  parameter logic [NARROW_W-1:0] SYNC_NARROW = 10'h3E0,
  parameter logic [WIDE_W-1:0]   SYNC_WIDE   = 12'hFC0
) (
  input  logic              frame_en_i,
  input  logic              narrow_i,
  input  logic              win_full_i,
  input  logic [WIDE_W-1:0] win_i,
  output logic              hit_o
);
  logic match_n, match_w;

  always_comb begin
    match_n = (win_i[NARROW_W-1:0] == SYNC_NARROW);
    match_w = (win_i == SYNC_WIDE);
    hit_o   = frame_en_i && win_full_i &&
              ((narrow_i == framer_pkg::MODE_NARROW) ? match_n : match_w);
  end
endmodule

// File: rtl/framer_boundary.sv
module framer_boundary #(
  parameter int NARROW_W = 10,
  parameter int WIDE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              narrow_i,
  input  logic              frame_en_i,
  input  logic              win_full_i,
  input  logic              hit_i,
  input  logic [WIDE_W-1:0] win_i,
  output logic [WIDE_W-1:0] char_o,
  output logic              valid_o,
  output logic              realign_o
);
  localparam int CNT_W = $clog2(WIDE_W);
  localparam logic [CNT_W-1:0] LIM_N = CNT_W'(NARROW_W - 1);
  localparam logic [CNT_W-1:0] LIM_W = CNT_W'(WIDE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, lim;
  logic [WIDE_W-1:0] char_q;
  logic              valid_q, valid_d, realign_q, realign_d;
  logic              last, load_char;

  always_comb begin
    lim       = (narrow_i == framer_pkg::MODE_NARROW) ? LIM_N : LIM_W;
    last      = (cnt_q >= lim);
    cnt_d     = cnt_q;
    valid_d   = 1'b0;
    realign_d = 1'b0;
    load_char = 1'b0;
    if (bit_en_i) begin
      if (hit_i && !last) begin
        realign_d = 1'b1;
        cnt_d     = '0;
      end else if (last) begin
        valid_d   = 1'b1;
        load_char = 1'b1;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      valid_q   <= 1'b0;
      realign_q <= 1'b0;
      char_q    <= '0;
    end else begin
      cnt_q     <= cnt_d;
      valid_q   <= valid_d;
      realign_q <= realign_d;
      if (load_char) char_q <= win_i;
    end
  end

  assign char_o    = char_q;
  assign valid_o   = valid_q;
  assign realign_o = realign_q;

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_realign_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    realign_q |=> !realign_q);

  p_realign_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    realign_q |-> $past(frame_en_i));

  p_realign_filled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    realign_q |-> $past(win_full_i));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(cnt_q) && !valid_q && !realign_q));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_W);
endmodule

// File: rtl/char_framer.sv
module char_framer #(
  parameter int                  NARROW_W    = framer_pkg::NARROW_W_DEF,
  parameter int                  WIDE_W      = framer_pkg::WIDE_W_DEF,
  parameter logic [NARROW_W-1:0] SYNC_NARROW = 10'h3E0,
  parameter logic [WIDE_W-1:0]   SYNC_WIDE   = 12'hFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              narrow_sel,
  input  logic              frame_en,
  output logic [WIDE_W-1:0] char_out,
  output logic              char_valid,
  output logic              realign
);
  logic [WIDE_W-1:0] win;
  logic              win_full;
  logic              hit;

  framer_shift #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en_i   (bit_en),
    .bit_in_i   (bit_in),
    .narrow_i   (narrow_sel),
    .win_o      (win),
    .win_full_o (win_full)
  );

  framer_sync_det #(
    .NARROW_W    (NARROW_W),
    .WIDE_W      (WIDE_W),
    .SYNC_NARROW (SYNC_NARROW),
    .SYNC_WIDE   (SYNC_WIDE)
  ) det_i (
    .frame_en_i (frame_en),
    .narrow_i   (narrow_sel),
    .win_full_i (win_full),
    .win_i      (win),
    .hit_o      (hit)
  );

  framer_boundary #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) bnd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en_i   (bit_en),
    .narrow_i   (narrow_sel),
    .frame_en_i (frame_en),
    .win_full_i (win_full),
    .hit_i      (hit),
    .win_i      (win),
    .char_o     (char_out),
    .valid_o    (char_valid),
    .realign_o  (realign)
  );

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(char_valid && realign));
endmodule

// File: tb/char_framer_tb_top.sv
`timescale 1ns/1ps
module char_framer_tb_top;
  localparam logic [9:0]  SYN10 = 10'h3E0;
  localparam logic [11:0] SYN12 = 12'hFC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        narrow_sel = 1'b1;
  logic        frame_en = 1'b0;
  logic [11:0] char_out;
  logic        char_valid;
  logic        realign;

  int tests = 0;
  int fails = 0;

  logic        strm [0:255];
  int          slen;
  logic [11:0] rx_char [0:63];
  int          rx_n, rl_n, rl_pos, fv_pos, consumed;
  logic [11:0] exp_c [0:7];
  int          exp_n;

  always #4 clk = ~clk;

  char_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .narrow_sel(narrow_sel), .frame_en(frame_en),
    .char_out(char_out), .char_valid(char_valid), .realign(realign)
  );

  always @(posedge clk) begin
    if (!rst_n) consumed <= 0;
    else if (bit_en) consumed <= consumed + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (char_valid) begin
        if (rx_n == 0) fv_pos = consumed;
        if (rx_n < 64) rx_char[rx_n] = char_out;
        rx_n = rx_n + 1;
      end
      if (realign) begin
        rl_n = rl_n + 1;
        rl_pos = consumed;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_n = 0; rl_n = 0; rl_pos = -1; fv_pos = -1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic add_bits(input logic [11:0] v, input int n);
    for (int b = 0; b < n; b++) begin
      strm[slen] = v[b];
      slen = slen + 1;
    end
  endtask

  task automatic add_alt(input int n, input logic first);
    for (int b = 0; b < n; b++) begin
      strm[slen] = first ^ logic'(b % 2);
      slen = slen + 1;
    end
  endtask

  function automatic logic [11:0] slice(input int s, input int n);
    logic [11:0] r = '0;
    for (int b = 0; b < n; b++) r[b] = strm[s + b];
    return r;
  endfunction

  task automatic play(input int gap);
    for (int i = 0; i < slen; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = strm[i];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bit_en = 1'b0;
      end
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_chars(input string tag);
    chk(rx_n == exp_n, {tag, " char count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(rx_char[i] == exp_c[i], {tag, " char value"}, rx_char[i], exp_c[i]);
  endtask

  // offset sweep: k filler bits, sync, four data characters
  task automatic sweep(input bit nar, input int k, input int gap);
    int n;
    logic [11:0] d [0:3];
    n = nar ? 10 : 12;
    if (nar) begin
      d[0] = 12'h155; d[1] = 12'h2AA; d[2] = 12'h133; d[3] = 12'h2CD;
    end else begin
      d[0] = 12'h555; d[1] = 12'hAAA; d[2] = 12'h333; d[3] = 12'hCCD;
    end
    narrow_sel = nar;
    frame_en = 1'b1;
    do_reset();
    slen = 0;
    add_alt(k, 1'b1);
    add_bits(nar ? {2'b00, SYN10} : SYN12, n);
    for (int i = 0; i < 4; i++) add_bits(d[i], n);
    play(gap);
    exp_n = 0;
    if (k == 0) begin
      exp_c[0] = nar ? {2'b00, SYN10} : SYN12;
      exp_n = 1;
      chk(rl_n == 0, "R6 aligned sync no realign", rl_n, 0);
    end else begin
      exp_c[0] = slice(0, n);
      exp_n = 1;
      chk(rl_n == 1, "R4 realign count", rl_n, 1);
      chk(rl_pos == k + n, "R4 realign timing", rl_pos, k + n);
    end
    for (int i = 0; i < 4; i++) begin
      exp_c[exp_n] = d[i];
      exp_n = exp_n + 1;
    end
    cmp_chars(nar ? "R2 R5 narrow" : "R3 R5 wide");
  endtask

  initial begin
    #1_000_000;
    fails = fails + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(char_valid == 1'b0 && realign == 1'b0, "R1 reset pulses", {char_valid, realign}, 0);
    chk(char_out == 12'h000, "R1 reset char", char_out, 0);

    // R9 start-up guard: five ones right after reset
    narrow_sel = 1'b1;
    frame_en = 1'b1;
    do_reset();
    slen = 0;
    add_bits(12'h01F, 5);
    add_alt(35, 1'b0);
    play(0);
    chk(rl_n == 0, "R9 no early match", rl_n, 0);
    chk(fv_pos == 10, "R1 first valid position", fv_pos, 10);
    exp_n = 4;
    for (int i = 0; i < 4; i++) exp_c[i] = slice(10 * i, 10);
    cmp_chars("R9 R2 boundary kept");

    // R2 R4 R5 R6 narrow offsets, R3 wide offsets
    for (int k = 0; k < 10; k++) sweep(1'b1, k, 0);
    for (int k = 0; k < 12; k++) sweep(1'b0, k, 0);

    // R10 idle gaps between bits
    sweep(1'b1, 3, 2);
    sweep(1'b0, 7, 1);

    // R7 framer disabled: boundary held through a sync pattern
    narrow_sel = 1'b1;
    frame_en = 1'b0;
    do_reset();
    slen = 0;
    add_alt(4, 1'b1);
    add_bits({2'b00, SYN10}, 10);
    add_alt(40, 1'b0);
    play(0);
    chk(rl_n == 0, "R7 no realign when disabled", rl_n, 0);
    exp_n = 5;
    for (int i = 0; i < 5; i++) exp_c[i] = slice(10 * i, 10);
    cmp_chars("R7 held boundary");

    // R8 narrow pattern in wide mode
    narrow_sel = 1'b0;
    frame_en = 1'b1;
    do_reset();
    slen = 0;
    add_alt(5, 1'b1);
    add_bits({2'b00, SYN10}, 10);
    add_alt(33, 1'b0);
    play(0);
    chk(rl_n == 0, "R8 wrong-width pattern ignored", rl_n, 0);
    exp_n = 4;
    for (int i = 0; i < 4; i++) exp_c[i] = slice(12 * i, 12);
    cmp_chars("R8 wide boundary");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule